// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block is a synchronous timekeeping register bank that occupies the eight highest byte addresses of a byte-wide memory map. It keeps seconds, minutes, hours, day-of-week, date, month, year and century as packed BCD. These fields advance once for each clock cycle in which a one-hertz enable is high.

A static-RAM-style byte port gives access to the registers. It has an active-low chip enable, an output enable and a write enable. Three control bits change how the bank behaves:
- An oscillator stop bit halts timekeeping.
- A write bit freezes the visible registers so software can load a new time. The loaded time is committed when the bit is cleared.
- A read bit freezes a coherent snapshot while the hidden counters keep running.

Top module: `rtc_regbank`

## Requirements
- R1: The bank responds only when every address bit above bit 2 is 1. Address bits 2:0 select the register: 7 year, 6 month, 5 date, 4 day/flags, 3 hours, 2 minutes, 1 seconds/stop, 0 century/control. Reads of other addresses leave `rdata_en_o` low, and writes to them change nothing.
- R2: While `ce_ni`=0, `oe_ni`=0 and `we_ni`=1 at a decoded address, `rdata_en_o` is 1 and `rdata_o` shows the selected register in the same cycle. At all other times both outputs are 0.
- R3: If `we_ni` falls while a read is in progress, `rdata_en_o` drops in that same cycle and the cycle performs a write.
- R4: A write takes effect only on the first rising clock edge at which `ce_ni` and `we_ni` are both low, whichever of the two went low last. It uses the address and data present at that edge. Holding both low for longer performs no further writes.
- R5: Each tick advances the time in packed BCD, with the tens digit in the upper bits and the units digit in bits 3:0. Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00. The visible registers follow the counters within two cycles.
- R6: An hours carry advances day-of-week, which wraps from 07 to 01. The same carry advances the date, which wraps to 01 after the last day of the month. February has 29 days when the year is divisible by four and 28 otherwise. April, June, September and November have 30 days.
- R7: A date wrap advances the month, which wraps from 12 to 01. A month wrap advances the year, which wraps from 99 to 00. A year wrap advances the century, which wraps from 39 to 00.
- R8: While bit 7 of the seconds register (stop) is 1, ticks have no effect. The stop bit can be written at any time.
- R9: Bit 7 of the century register is the write bit. Writes to the time fields take effect only while the write bit is already 1. While it is 1 the visible registers stop updating and the hidden counters keep counting. Writing 0 to it loads the counters with the visible values, including the century field from that same write.
- R10: Bit 6 of the century register is the read bit. While it is 1 the visible registers hold their value and ticks still advance the hidden counters. After it is cleared, the visible registers show the advanced time.
- R11: Read formats are as follows. Reset gives time 00:00:00, day 01, date 01, month 01, year 00, century 00, with all control bits 0. Unused bits read 0. Day register bit 7 (battery good) reads 1. Day register bit 6 (frequency test) can be written at any time and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-hertz enable, one cycle wide |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when not driving |
| rdata_en_o | output | 1 | Read data drive enable |

## Verification
The bench loads times just before each rollover. It targets the end of a leap February and a non-leap February, a 30-day month, and the wrap of the whole calendar from 39 99-12-31 23:59:59 to all zeros. A wrong month-length table or a wrong carry order would show up there as a wrong date or month.

It also checks three freeze cases:
- A write-bit freeze that absorbs ticks. A leak would show up as a changed visible second.
- A read-bit snapshot that must catch up once cleared. A missed count would show up as a stale second.
- Time-field writes with the write bit clear. A design that accepts them would corrupt the time.

Held write cycles with the data changed after the first edge catch designs that write on every cycle instead of once. Dropping write enable in the middle of a read catches designs that keep driving the bus.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = 3;

  localparam logic [IDX_W-1:0] IDX_CENT = 3'd0;
  localparam logic [IDX_W-1:0] IDX_SEC  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_MIN  = 3'd2;
  localparam logic [IDX_W-1:0] IDX_HOUR = 3'd3;
  localparam logic [IDX_W-1:0] IDX_DAY  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_DATE = 3'd5;
  localparam logic [IDX_W-1:0] IDX_MON  = 3'd6;
  localparam logic [IDX_W-1:0] IDX_YEAR = 3'd7;

  typedef struct packed {
    logic [BYTE_W-1:0] century;
    logic [BYTE_W-1:0] year;
    logic [BYTE_W-1:0] month;
    logic [BYTE_W-1:0] date;
    logic [BYTE_W-1:0] day;
    logic [BYTE_W-1:0] hours;
    logic [BYTE_W-1:0] minutes;
    logic [BYTE_W-1:0] seconds;
  } time_t;

  localparam time_t TIME_RST = '{century: 8'h00, year: 8'h00, month: 8'h01,
                                 date: 8'h01, day: 8'h01, hours: 8'h00,
                                 minutes: 8'h00, seconds: 8'h00};

  // returns {carry, next}
  function automatic logic [BYTE_W:0] bcd_step(input logic [BYTE_W-1:0] v,
                                               input logic [BYTE_W-1:0] top,
                                               input logic [BYTE_W-1:0] bottom);
    logic [BYTE_W:0] r;
    if (v == top)             r = {1'b1, bottom};
    else if (v[3:0] == 4'h9)  r = {1'b0, v[7:4] + 4'h1, 4'h0};
    else                      r = {1'b0, v[7:4], v[3:0] + 4'h1};
    return r;
  endfunction

  function automatic logic leap_year(input logic [BYTE_W-1:0] yr);
    logic l;
    if (!yr[4]) l = (yr[3:0] == 4'h0) || (yr[3:0] == 4'h4) || (yr[3:0] == 4'h8);
    else        l = (yr[3:0] == 4'h2) || (yr[3:0] == 4'h6);
    return l;
  endfunction

  function automatic logic [BYTE_W-1:0] month_len(input logic [BYTE_W-1:0] mon,
                                                  input logic [BYTE_W-1:0] yr);
    logic [BYTE_W-1:0] n;
    case (mon)
      8'h02:                      n = leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: n = 8'h30;
      default:                    n = 8'h31;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/rtc_bus_decode.sv
`timescale 1ns/1ps
module rtc_bus_decode
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              rd_en_o,
  output logic              wr_stb_o
);
  localparam int unsigned TOP_W = ADDR_W - IDX_W;

  logic              hit;
  logic              wr_act;
  logic              wr_act_q;
  logic [TOP_W-1:0]  top_bits;

  assign top_bits = addr_i[ADDR_W-1:IDX_W];
  assign hit      = &top_bits;
  assign idx_o    = addr_i[IDX_W-1:0];
  assign wr_act   = !ce_ni && !we_ni;
  assign rd_en_o  = hit && !ce_ni && !oe_ni && we_ni;
  // write referenced to the later of the two enables
  assign wr_stb_o = hit && wr_act && !wr_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_act_q <= 1'b0;
    else         wr_act_q <= wr_act;
  end

  assert_one_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);
  assert_no_rd_in_wr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> !rd_en_o);
endmodule

// File: rtl/rtc_time_chain.sv
`timescale 1ns/1ps
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  stop_i,
  input  logic  load_i,
  input  time_t load_val_i,
  output time_t cnt_o
);
  time_t cnt_q;
  time_t cnt_nxt;

  always_comb begin
    logic [BYTE_W:0] s, m, h, d, dt, mo, y, c;
    cnt_nxt = cnt_q;
    s = '0; m = '0; h = '0; d = '0; dt = '0; mo = '0; y = '0; c = '0;
    if (tick_i && !stop_i) begin
      s = bcd_step(cnt_q.seconds, 8'h59, 8'h00);
      cnt_nxt.seconds = s[BYTE_W-1:0];
      if (s[BYTE_W]) begin
        m = bcd_step(cnt_q.minutes, 8'h59, 8'h00);
        cnt_nxt.minutes = m[BYTE_W-1:0];
      end
      if (m[BYTE_W]) begin
        h = bcd_step(cnt_q.hours, 8'h23, 8'h00);
        cnt_nxt.hours = h[BYTE_W-1:0];
      end
      if (h[BYTE_W]) begin
        d  = bcd_step(cnt_q.day, 8'h07, 8'h01);
        dt = bcd_step(cnt_q.date, month_len(cnt_q.month, cnt_q.year), 8'h01);
        cnt_nxt.day  = d[BYTE_W-1:0];
        cnt_nxt.date = dt[BYTE_W-1:0];
      end
      if (dt[BYTE_W]) begin
        mo = bcd_step(cnt_q.month, 8'h12, 8'h01);
        cnt_nxt.month = mo[BYTE_W-1:0];
      end
      if (mo[BYTE_W]) begin
        y = bcd_step(cnt_q.year, 8'h99, 8'h00);
        cnt_nxt.year = y[BYTE_W-1:0];
      end
      if (y[BYTE_W]) begin
        c = bcd_step(cnt_q.century, 8'h39, 8'h00);
        cnt_nxt.century = c[BYTE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= TIME_RST;
    else if (load_i) cnt_q <= load_val_i;
    else             cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;

  assert_stop_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !load_i) |=> $stable(cnt_q));
  assert_load_value_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
  assert_sec_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !stop_i && !load_i && cnt_q.seconds == 8'h59) |=> (cnt_q.seconds == 8'h00));
  assert_day_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q.day != 8'h07) |=> (cnt_q.day != 8'h00));
endmodule

// File: rtl/rtc_regbank.sv
`timescale 1ns/1ps
module rtc_regbank
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              rdata_en_o
);
  logic [IDX_W-1:0] idx;
  logic             rd_en;
  logic             wr_stb;
  logic             w_q, r_q, stop_q, ft_q;
  logic             load;
  time_t            cnt;
  time_t            usr_q;
  time_t            usr_nxt;

  rtc_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .we_ni    (we_ni),
    .addr_i   (addr_i),
    .idx_o    (idx),
    .rd_en_o  (rd_en),
    .wr_stb_o (wr_stb)
  );

  assign load = wr_stb && (idx == IDX_CENT) && w_q && !wdata_i[7];

  rtc_time_chain u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .stop_i     (stop_q),
    .load_i     (load),
    .load_val_i (usr_nxt),
    .cnt_o      (cnt)
  );

  // visible registers: mirror, frozen, or written
  always_comb begin
    usr_nxt = usr_q;
    if (!w_q && !r_q) usr_nxt = cnt;
    if (wr_stb && w_q) begin
      case (idx)
        IDX_CENT: usr_nxt.century = {2'b00, wdata_i[5:0]};
        IDX_SEC:  usr_nxt.seconds = {1'b0, wdata_i[6:0]};
        IDX_MIN:  usr_nxt.minutes = {1'b0, wdata_i[6:0]};
        IDX_HOUR: usr_nxt.hours   = {2'b00, wdata_i[5:0]};
        IDX_DAY:  usr_nxt.day     = {5'b0, wdata_i[2:0]};
        IDX_DATE: usr_nxt.date    = {2'b00, wdata_i[5:0]};
        IDX_MON:  usr_nxt.month   = {3'b0, wdata_i[4:0]};
        default:  usr_nxt.year    = wdata_i;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      usr_q  <= TIME_RST;
      w_q    <= 1'b0;
      r_q    <= 1'b0;
      stop_q <= 1'b0;
      ft_q   <= 1'b0;
    end else begin
      usr_q <= usr_nxt;
      if (wr_stb) begin
        case (idx)
          IDX_CENT: begin
            w_q <= wdata_i[7];
            r_q <= wdata_i[6];
          end
          IDX_SEC: stop_q <= wdata_i[7];
          IDX_DAY: ft_q   <= wdata_i[6];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      case (idx)
        IDX_CENT: rdata_o = {w_q, r_q, usr_q.century[5:0]};
        IDX_SEC:  rdata_o = {stop_q, usr_q.seconds[6:0]};
        IDX_MIN:  rdata_o = {1'b0, usr_q.minutes[6:0]};
        IDX_HOUR: rdata_o = {2'b00, usr_q.hours[5:0]};
        IDX_DAY:  rdata_o = {1'b1, ft_q, 3'b000, usr_q.day[2:0]};
        IDX_DATE: rdata_o = {2'b00, usr_q.date[5:0]};
        IDX_MON:  rdata_o = {3'b000, usr_q.month[4:0]};
        default:  rdata_o = usr_q.year;
      endcase
    end
  end
  assign rdata_en_o = rd_en;

  assert_bus_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || oe_ni || !we_ni) |-> (!rdata_en_o && rdata_o == 8'h00));
  assert_read_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_q && !wr_stb) |=> $stable(usr_q));
  assert_write_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_q && !wr_stb) |=> $stable(usr_q));
  assert_batt_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_en_o && idx == IDX_DAY) |-> (rdata_o[7] && rdata_o[5:3] == 3'b000));
endmodule

// File: tb/rtc_regbank_bench.sv
`timescale 1ns/1ps
module rtc_regbank_bench;
  localparam int unsigned AW = 15;
  localparam logic [AW-1:0] BASE = 15'h7FF8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rdata_en;

  int n_checks = 0;
  int n_errors = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  rtc_regbank #(.ADDR_W(AW)) u_rtc_regbank (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ce_ni(ce_n), .oe_ni(oe_n),
    .we_ni(we_n), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rdata_en_o(rdata_en)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pop on every driven read
  always @(negedge clk) begin
    if (rdata_en && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, rdata, e);
    end
  end

  task automatic rd(input logic [2:0] idx, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    addr = BASE + AW'(idx); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(posedge clk); #1;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wr_addr(input logic [AW-1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
    @(posedge clk); #1;
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [7:0] d);
    wr_addr(BASE + AW'(idx), d);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tick = 1'b1;
      @(posedge clk); #1 tick = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] cen, input logic [7:0] yr, input logic [7:0] mo,
                          input logic [7:0] dt, input logic [7:0] dy, input logic [7:0] hr,
                          input logic [7:0] mi, input logic [7:0] se);
    wr(3'd0, 8'h80);
    wr(3'd7, yr); wr(3'd6, mo); wr(3'd5, dt); wr(3'd4, dy);
    wr(3'd3, hr); wr(3'd2, mi); wr(3'd1, se);
    wr(3'd0, cen);
  endtask

  initial begin
    #2_000_000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset values and formats
    rd(3'd7, 8'h00, "R11 reset year");
    rd(3'd6, 8'h01, "R11 reset month");
    rd(3'd5, 8'h01, "R11 reset date");
    rd(3'd4, 8'h81, "R11 reset day/battery");
    rd(3'd3, 8'h00, "R11 reset hours");
    rd(3'd1, 8'h00, "R11 reset seconds");
    rd(3'd0, 8'h00, "R11 reset century");

    // R9 time write ignored while write bit clear
    wr(3'd1, 8'h25);
    rd(3'd1, 8'h00, "R9 write ignored without W");

    // R9 write freeze, hidden counting, load on clear
    wr(3'd0, 8'h80);
    wr(3'd7, 8'h99); wr(3'd6, 8'h12); wr(3'd5, 8'h31); wr(3'd4, 8'h07);
    wr(3'd3, 8'h23); wr(3'd2, 8'h59); wr(3'd1, 8'h58);
    rd(3'd1, 8'h58, "R9 seconds written under W");
    rd(3'd0, 8'h80, "R9 W bit readback");
    ticks(3);
    rd(3'd1, 8'h58, "R9 visible frozen during W");
    wr(3'd0, 8'h39);
    rd(3'd1, 8'h58, "R9 counters loaded on clear");
    rd(3'd0, 8'h39, "R9 century loaded");
    ticks(1);
    rd(3'd1, 8'h59, "R5 seconds advance");
    ticks(1);
    // R5 R6 R7 full wrap
    rd(3'd1, 8'h00, "R5 seconds wrap");
    rd(3'd2, 8'h00, "R5 minutes wrap");
    rd(3'd3, 8'h00, "R5 hours wrap");
    rd(3'd4, 8'h81, "R6 day 07->01");
    rd(3'd5, 8'h01, "R6 date 31->01");
    rd(3'd6, 8'h01, "R7 month 12->01");
    rd(3'd7, 8'h00, "R7 year 99->00");
    rd(3'd0, 8'h00, "R7 century 39->00");

    // R6 leap February
    set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    ticks(1);
    rd(3'd5, 8'h29, "R6 leap Feb 28->29");
    rd(3'd6, 8'h02, "R6 leap stays Feb");
    rd(3'd4, 8'h84, "R6 day 03->04");
    set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    ticks(1);
    rd(3'd5, 8'h01, "R6 non-leap Feb 28->01");
    rd(3'd6, 8'h03, "R6 non-leap into March");
    set_time(8'h20, 8'h23, 8'h04, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59);
    ticks(1);
    rd(3'd5, 8'h01, "R6 April 30->01");
    rd(3'd6, 8'h05, "R7 month 04->05");

    // R8 stop bit
    wr(3'd1, 8'h80);
    rd(3'd1, 8'h80, "R8 stop set");
    ticks(3);
    rd(3'd1, 8'h80, "R8 no advance while stopped");
    rd(3'd2, 8'h00, "R8 minutes unchanged");
    wr(3'd1, 8'h00);
    ticks(1);
    rd(3'd1, 8'h01, "R8 resumes after clear");

    // R10 read snapshot
    wr(3'd0, 8'h40);
    rd(3'd0, 8'h60, "R10 R bit readback");
    ticks(2);
    rd(3'd1, 8'h01, "R10 snapshot held");
    wr(3'd0, 8'h00);
    rd(3'd1, 8'h03, "R10 catches up after clear");
    rd(3'd0, 8'h20, "R10 century untouched");

    // R1 outside the decoded window
    @(posedge clk); #1;
    addr = 15'h7FF7; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #2 check("R1 no drive below window", {7'b0, rdata_en}, 8'h00);
    check("R1 data zero below window", rdata, 8'h00);
    @(posedge clk); #1 ce_n = 1'b1; oe_n = 1'b1;
    wr(3'd0, 8'h80);
    wr_addr(15'h0007, 8'h55);
    rd(3'd7, 8'h23, "R1 write below window ignored");
    wr(3'd0, 8'h20);

    // R3 write enable falling during a read
    wr(3'd0, 8'hA0);
    @(posedge clk); #1;
    addr = BASE + 15'd2; wdata = 8'h42; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #2 check("R2 read drives", {7'b0, rdata_en}, 8'h01);
    check("R2 read data minutes", rdata, 8'h00);
    @(posedge clk); #1 we_n = 1'b0;
    #1 check("R3 drive off when WE falls", {7'b0, rdata_en}, 8'h00);
    @(posedge clk); #1 ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    wr(3'd0, 8'h20);
    rd(3'd2, 8'h42, "R3 write performed");

    // R4 WE first then CE, held with data change; FT bit (R11)
    @(posedge clk); #1;
    addr = BASE + 15'd4; wdata = 8'h40; we_n = 1'b0; ce_n = 1'b1;
    @(posedge clk); #1 ce_n = 1'b0;
    @(posedge clk); #1 wdata = 8'h00;
    @(posedge clk); @(posedge clk); #1 ce_n = 1'b1; we_n = 1'b1;
    rd(3'd4, 8'hC4, "R4 single write on later enable, R11 FT stored");
    // CE first then WE
    @(posedge clk); #1;
    addr = BASE + 15'd4; wdata = 8'h00; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
    @(posedge clk); #1 we_n = 1'b0;
    @(posedge clk); #1 wdata = 8'h40;
    @(posedge clk); #1 ce_n = 1'b1; we_n = 1'b1;
    rd(3'd4, 8'h84, "R4 write when WE asserts last");

    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_checks++; n_errors++;
      $display("FAIL R2: actual=%0d pending reads expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule